// File: doc/BRIEF.md
# Timer Capture/Compare Unit

A 16-bit timer with a selectable prescaler feeds a single 16-bit capture/compare register. In the capture modes, a chosen edge pattern on an external event pin makes the register take a snapshot of the timer. In compare mode, the register holds a value loaded by software. When the timer reaches that value on a prescaled tick, the timer wraps back to zero and an event is reported. This gives a programmable period of (compare value + 1) prescaled ticks.

Capture and compare report through one sticky event flag. Software clears the flag with a clear strobe, and the flag drives an interrupt request only when the interrupt enable is high. The timer and the register are both loaded one byte at a time through a shared 8-bit write-data port with separate low-byte and high-byte strobes. Address decoding belongs to the surrounding bus logic.

Top module: `tcc_unit`

## Requirements
- R1: After synchronous reset, the timer, the capture/compare register, the flag and the interrupt request are all zero.
- R2: While `tmr_run` is high, the timer advances by one every 2^`pre_sel` clocks (`pre_sel` 0,1,2,3 gives divide by 1,2,4,8), counted from the last timer write. While `tmr_run` is low, the timer holds its value.
- R3: `tmr_wr_lo` loads `wdata` into timer bits [7:0] and `tmr_wr_hi` loads it into bits [15:8]. A timer write takes priority over counting and also restarts the prescaler phase.
- R4: `ccr_wr_lo` and `ccr_wr_hi` load `wdata` into register bits [7:0] and [15:8] respectively. A software write takes priority over a capture in the same cycle.
- R5: In mode 1 (falling-edge capture), a falling edge on `evt_pin` copies the timer into the register and sets the flag. The copy is visible after the third rising clock edge following the pin change (two synchronizer flops plus one edge register). Rising edges have no effect in this mode.
- R6: In mode 2 (rising-edge capture), each rising edge on `evt_pin` captures with the same latency as R5. Falling edges have no effect.
- R7: In mode 3, every 4th rising edge captures; in mode 4, every 16th rising edge captures. The edge count restarts whenever `mode` changes.
- R8: In mode 5 (compare), a prescaled tick that finds the timer equal to the register sends the timer to 0 instead of incrementing it, and sets the flag. The period is therefore (register + 1) ticks.
- R9: The flag stays set until `flag_clr`. A new event in the same cycle as `flag_clr` wins and leaves the flag set. A capture while the flag is already set still overwrites the register.
- R10: `irq` is high exactly when the flag and `irq_en` are both high.
- R11: Modes 0, 6 and 7 and compare mode ignore the event pin (the register and the flag are unchanged). In modes other than 5, the timer equal to the register does not reset the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_run | input | 1 | Timer run enable |
| pre_sel | input | 2 | Prescale select, divide by 2^pre_sel |
| mode | input | 3 | 0 off, 1 fall capture, 2 rise capture, 3 every 4th rise, 4 every 16th rise, 5 compare, 6-7 off |
| wdata | input | 8 | Byte write data |
| tmr_wr_lo | input | 1 | Load timer low byte |
| tmr_wr_hi | input | 1 | Load timer high byte |
| ccr_wr_lo | input | 1 | Load register low byte |
| ccr_wr_hi | input | 1 | Load register high byte |
| flag_clr | input | 1 | Clear the event flag |
| irq_en | input | 1 | Interrupt enable |
| evt_pin | input | 1 | Asynchronous external event pin |
| tmr_value | output | 16 | Current timer value |
| ccr_value | output | 16 | Capture/compare register |
| flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
Capture is tried with single rising and falling pulses against a stopped timer set to distinct values. This separates the edge polarity of mode 1 from mode 2 and pins the exact three-clock latency. Trains of 3, 4, 15 and 16 pulses separate the divided modes, and a mode switch in the middle of a train shows that the edge count restarts. Compare runs at divide-by-1 with a cycle-by-cycle model of the timer sequence, and at divide-by-8 sampled one clock before and one clock after the wrap, which tells a period of (value + 1) ticks from one of value ticks. Pin pulses in the off and compare modes and a timer sweeping past the register value in capture mode show the inputs that must have no effect.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int BYTE_W_DEF = 8;
    localparam int PRE_SEL_W  = 2;
    localparam int MODE_W     = 3;
    localparam int EDGE_CNT_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF        = 3'd0,
        MODE_CAP_FALL   = 3'd1,
        MODE_CAP_RISE   = 3'd2,
        MODE_CAP_RISE4  = 3'd3,
        MODE_CAP_RISE16 = 3'd4,
        MODE_COMPARE    = 3'd5
    } mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } byte_wr_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic capture;
        logic match;
    } evt_t;

    function automatic logic mode_is_divided(input logic [MODE_W-1:0] m);
        return (m == MODE_CAP_RISE4) || (m == MODE_CAP_RISE16);
    endfunction

    function automatic logic mode_is_capture(input logic [MODE_W-1:0] m);
        return (m == MODE_CAP_FALL) || (m == MODE_CAP_RISE) || mode_is_divided(m);
    endfunction

    // last value of the rising-edge counter before a divided capture fires
    function automatic logic [EDGE_CNT_W-1:0] edge_limit(input logic [MODE_W-1:0] m);
        return (m == MODE_CAP_RISE16) ? EDGE_CNT_W'(15) : EDGE_CNT_W'(3);
    endfunction

endpackage

// File: rtl/tcc_prescaler.sv
module tcc_prescaler
    import tcc_pkg::*;
#(
    parameter int SEL_W = PRE_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    assign mask = ONES >> (CNT_W - int'(sel));
    assign tick = run && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: undivided setting ticks on every running clock
    assert_full_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (run && sel == '0) |-> tick);

    // R2: no tick while stopped
    assert_no_tick_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

endmodule

// File: rtl/tcc_timer.sv
module tcc_timer
    import tcc_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                match,
    input  byte_wr_t            wr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] value
);
    localparam int TMR_W = 2 * BYTE_W;

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr.lo || wr.hi) begin
            if (wr.lo) cnt_q[BYTE_W-1:0]     <= wdata;
            if (wr.hi) cnt_q[TMR_W-1:BYTE_W] <= wdata;
        end else if (tick) begin
            cnt_q <= match ? '0 : cnt_q + 1'b1;
        end
    end

    assign value = cnt_q;

    // R8: a compare match sends the timer to zero on the next edge
    assert_wrap_on_match_R8: assert property (@(posedge clk) disable iff (rst)
        (match && !wr.lo && !wr.hi) |=> (value == '0));

    // R2: without tick or write, the timer holds
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr.lo && !wr.hi) |=> $stable(value));

endmodule

// File: rtl/tcc_edge_detect.sv
module tcc_edge_detect
    import tcc_pkg::*;
#(
    parameter int CNT_W = EDGE_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  logic [MODE_W-1:0] mode,
    output logic              capture
);
    logic             sync1_q, sync2_q, prev_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0] ecnt_q;
    edge_t            edg;
    logic             at_limit;
    logic             mode_changed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
            mode_q  <= '0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            mode_q  <= mode;
        end
    end

    assign edg.rise     = sync2_q && !prev_q;
    assign edg.fall     = !sync2_q && prev_q;
    assign mode_changed = (mode != mode_q);
    assign at_limit     = (ecnt_q == CNT_W'(edge_limit(mode)));

    always_ff @(posedge clk) begin
        if (rst || mode_changed) begin
            ecnt_q <= '0;
        end else if (edg.rise && mode_is_divided(mode)) begin
            ecnt_q <= at_limit ? '0 : ecnt_q + 1'b1;
        end
    end

    always_comb begin
        case (mode)
            MODE_CAP_FALL:   capture = edg.fall;
            MODE_CAP_RISE:   capture = edg.rise;
            MODE_CAP_RISE4,
            MODE_CAP_RISE16: capture = edg.rise && at_limit && !mode_changed;
            default:         capture = 1'b0;
        endcase
    end

    // R7: a divided capture resets the edge count
    assert_count_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (capture && mode_is_divided(mode)) |=> (ecnt_q == '0));

    // R7: a mode change restarts the edge count
    assert_mode_restart_R7: assert property (@(posedge clk) disable iff (rst)
        mode_changed |=> (ecnt_q == '0) || $rose(edg.rise));

endmodule

// File: rtl/tcc_ccr.sv
module tcc_ccr
    import tcc_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  byte_wr_t            wr,
    input  logic [BYTE_W-1:0]   wdata,
    input  evt_t                evt,
    input  logic [2*BYTE_W-1:0] tmr,
    input  logic                flag_clr,
    output logic [2*BYTE_W-1:0] ccr,
    output logic                flag
);
    localparam int TMR_W = 2 * BYTE_W;

    logic [TMR_W-1:0] ccr_q;
    logic             flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= '0;
        end else if (wr.lo || wr.hi) begin
            if (wr.lo) ccr_q[BYTE_W-1:0]     <= wdata;
            if (wr.hi) ccr_q[TMR_W-1:BYTE_W] <= wdata;
        end else if (evt.capture) begin
            ccr_q <= tmr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (evt.capture || evt.match) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign ccr  = ccr_q;
    assign flag = flag_q;

    // R5: a capture stores the timer value of its cycle
    assert_capture_loads_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.capture && !wr.lo && !wr.hi) |=> (ccr == $past(tmr)));

    // R9: the flag is sticky without a clear
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R9: an event beats a simultaneous clear
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (evt.capture || evt.match) |=> flag);

endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
    import tcc_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int SEL_W  = PRE_SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tmr_run,
    input  logic [SEL_W-1:0]    pre_sel,
    input  logic [MODE_W-1:0]   mode,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                tmr_wr_lo,
    input  logic                tmr_wr_hi,
    input  logic                ccr_wr_lo,
    input  logic                ccr_wr_hi,
    input  logic                flag_clr,
    input  logic                irq_en,
    input  logic                evt_pin,
    output logic [2*BYTE_W-1:0] tmr_value,
    output logic [2*BYTE_W-1:0] ccr_value,
    output logic                flag,
    output logic                irq
);
    localparam int TMR_W = 2 * BYTE_W;

    byte_wr_t         tmr_wr, ccr_wr;
    logic             tick;
    evt_t             evt;
    logic [TMR_W-1:0] tmr, ccr;

    assign tmr_wr.lo = tmr_wr_lo;
    assign tmr_wr.hi = tmr_wr_hi;
    assign ccr_wr.lo = ccr_wr_lo;
    assign ccr_wr.hi = ccr_wr_hi;

    tcc_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .restart (tmr_wr_lo || tmr_wr_hi),
        .sel     (pre_sel),
        .tick    (tick)
    );

    // equality comparator, active only in compare mode on a prescaled tick
    assign evt.match = tick && (mode == MODE_COMPARE) && (tmr == ccr);

    tcc_timer #(.BYTE_W(BYTE_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .match (evt.match),
        .wr    (tmr_wr),
        .wdata (wdata),
        .value (tmr)
    );

    tcc_edge_detect #(.CNT_W(EDGE_CNT_W)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .pin     (evt_pin),
        .mode    (mode),
        .capture (evt.capture)
    );

    tcc_ccr #(.BYTE_W(BYTE_W)) u_ccr (
        .clk      (clk),
        .rst      (rst),
        .wr       (ccr_wr),
        .wdata    (wdata),
        .evt      (evt),
        .tmr      (tmr),
        .flag_clr (flag_clr),
        .ccr      (ccr),
        .flag     (flag)
    );

    assign tmr_value = tmr;
    assign ccr_value = ccr;
    assign irq       = flag && irq_en;

    // R11: pin events never fire outside the capture modes
    assert_pin_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        !mode_is_capture(mode) |-> !evt.capture);

    // R11: outside compare mode a tick always increments the timer
    assert_free_run_R11: assert property (@(posedge clk) disable iff (rst)
        (tick && mode != MODE_COMPARE && !tmr_wr_lo && !tmr_wr_hi)
        |=> (tmr_value == $past(tmr_value) + 1'b1));

    // R10: request follows the flag when enabled
    assert_irq_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_en && $rose(flag)) |-> irq);

endmodule

// File: tb/tcc_unit_test.sv
module tcc_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_run = 1'b0;
    logic [1:0]  pre_sel = '0;
    logic [2:0]  mode = '0;
    logic [7:0]  wdata = '0;
    logic        tmr_wr_lo = 1'b0, tmr_wr_hi = 1'b0;
    logic        ccr_wr_lo = 1'b0, ccr_wr_hi = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        evt_pin = 1'b0;
    logic [15:0] tmr_value, ccr_value;
    logic        flag, irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcc_unit uut (
        .clk(clk), .rst(rst), .tmr_run(tmr_run), .pre_sel(pre_sel), .mode(mode),
        .wdata(wdata), .tmr_wr_lo(tmr_wr_lo), .tmr_wr_hi(tmr_wr_hi),
        .ccr_wr_lo(ccr_wr_lo), .ccr_wr_hi(ccr_wr_hi), .flag_clr(flag_clr),
        .irq_en(irq_en), .evt_pin(evt_pin), .tmr_value(tmr_value),
        .ccr_value(ccr_value), .flag(flag), .irq(irq)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_tmr(input logic [15:0] v);
        wdata = v[7:0]; tmr_wr_lo = 1'b1; step(1);
        tmr_wr_lo = 1'b0; wdata = v[15:8]; tmr_wr_hi = 1'b1; step(1);
        tmr_wr_hi = 1'b0;
    endtask

    task automatic wr_ccr(input logic [15:0] v);
        wdata = v[7:0]; ccr_wr_lo = 1'b1; step(1);
        ccr_wr_lo = 1'b0; wdata = v[15:8]; ccr_wr_hi = 1'b1; step(1);
        ccr_wr_hi = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    endtask

    task automatic pulse();
        evt_pin = 1'b1; step(4);
        evt_pin = 1'b0; step(4);
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode = m; step(2);
    endtask

    task automatic t_reset();
        chk(tmr_value == 0, "R1 timer", tmr_value, 0);
        chk(ccr_value == 0, "R1 ccr", ccr_value, 0);
        chk(flag == 0, "R1 flag", flag, 0);
        chk(irq == 0, "R1 irq", irq, 0);
    endtask

    task automatic t_writes();
        wr_tmr(16'hA55A);
        chk(tmr_value == 16'hA55A, "R3 timer bytes", tmr_value, 16'hA55A);
        wdata = 8'h3C; tmr_wr_lo = 1'b1; step(1); tmr_wr_lo = 1'b0;
        chk(tmr_value == 16'hA53C, "R3 low byte only", tmr_value, 16'hA53C);
        wr_ccr(16'h1E2F);
        chk(ccr_value == 16'h1E2F, "R4 ccr bytes", ccr_value, 16'h1E2F);
    endtask

    task automatic t_prescale(input int sel, input int k);
        tmr_run = 1'b0; mode = 3'd0;
        wr_tmr(16'h0000);
        pre_sel = 2'(sel); tmr_run = 1'b1; step(k); tmr_run = 1'b0;
        chk(tmr_value == 16'(k >> sel), "R2 prescale rate", tmr_value, k >> sel);
        step(5);
        chk(tmr_value == 16'(k >> sel), "R2 hold when stopped", tmr_value, k >> sel);
    endtask

    task automatic t_cap_fall();
        tmr_run = 1'b0; set_mode(3'd1);
        wr_tmr(16'h1234); wr_ccr(16'h0000); clr_flag();
        evt_pin = 1'b1; step(4);
        chk(ccr_value == 0 && flag == 0, "R5 rise ignored in fall mode", ccr_value, 0);
        evt_pin = 1'b0; step(2);
        chk(ccr_value == 0, "R5 latency not yet", ccr_value, 0);
        step(1);
        chk(ccr_value == 16'h1234, "R5 fall capture", ccr_value, 16'h1234);
        chk(flag == 1, "R5 flag set", flag, 1);
        step(3);
    endtask

    task automatic t_cap_rise();
        set_mode(3'd2); wr_tmr(16'hBEEF); wr_ccr(16'h0000); clr_flag();
        evt_pin = 1'b1; step(2);
        chk(ccr_value == 0, "R6 latency not yet", ccr_value, 0);
        step(1);
        chk(ccr_value == 16'hBEEF && flag == 1, "R6 rise capture", ccr_value, 16'hBEEF);
        clr_flag(); wr_ccr(16'h0000);
        evt_pin = 1'b0; step(4);
        chk(ccr_value == 0 && flag == 0, "R6 fall ignored", ccr_value, 0);
        // overwrite while flag is set
        pulse();
        wr_tmr(16'h0102);
        chk(flag == 1, "R9 flag set before overwrite", flag, 1);
        pulse();
        chk(ccr_value == 16'h0102, "R9 capture overwrites", ccr_value, 16'h0102);
        chk(flag == 1, "R9 flag still set", flag, 1);
    endtask

    task automatic t_cap_div(input logic [2:0] m, input int n, input logic [15:0] v);
        set_mode(m); wr_tmr(v); wr_ccr(16'h0000); clr_flag();
        for (int i = 0; i < n - 1; i++) pulse();
        chk(ccr_value == 0 && flag == 0, "R7 no capture before Nth edge", ccr_value, 0);
        pulse();
        chk(ccr_value == v && flag == 1, "R7 capture on Nth edge", ccr_value, v);
    endtask

    task automatic t_mode_restart();
        set_mode(3'd3); wr_ccr(16'h0000); wr_tmr(16'h0777); clr_flag();
        pulse(); pulse();
        set_mode(3'd0); set_mode(3'd3);
        pulse(); pulse(); pulse();
        chk(flag == 0 && ccr_value == 0, "R7 count restarts on mode change", flag, 0);
        pulse();
        chk(flag == 1 && ccr_value == 16'h0777, "R7 capture after restart", ccr_value, 16'h0777);
    endtask

    task automatic t_compare_fast();
        int e;
        tmr_run = 1'b0; set_mode(3'd5); pre_sel = 2'd0;
        wr_ccr(16'd5); wr_tmr(16'd0); clr_flag();
        e = 0;
        tmr_run = 1'b1;
        for (int i = 1; i <= 13; i++) begin
            step(1);
            e = (e == 5) ? 0 : e + 1;
            chk(tmr_value == 16'(e), "R8 compare sequence", tmr_value, e);
            if (i == 5) chk(flag == 0, "R8 no flag before wrap", flag, 0);
            if (i == 6) chk(flag == 1, "R8 flag on wrap", flag, 1);
        end
        tmr_run = 1'b0;
    endtask

    task automatic t_compare_div8();
        set_mode(3'd5); pre_sel = 2'd3;
        wr_ccr(16'd3); wr_tmr(16'd0); clr_flag();
        tmr_run = 1'b1; step(31);
        chk(tmr_value == 3 && flag == 0, "R8 divided period not yet", tmr_value, 3);
        step(1);
        chk(tmr_value == 0 && flag == 1, "R8 period value+1 ticks", tmr_value, 0);
        tmr_run = 1'b0;
    endtask

    task automatic t_set_beats_clear();
        set_mode(3'd5); pre_sel = 2'd0;
        wr_ccr(16'd5); wr_tmr(16'd0); clr_flag();
        flag_clr = 1'b1; tmr_run = 1'b1; step(6);
        chk(flag == 1 && tmr_value == 0, "R9 event beats clear", flag, 1);
        step(1);
        chk(flag == 0, "R9 clear without event", flag, 0);
        flag_clr = 1'b0; tmr_run = 1'b0;
    endtask

    task automatic t_ignore();
        logic [2:0] offm [3] = '{3'd0, 3'd6, 3'd5};
        tmr_run = 1'b0;
        foreach (offm[i]) begin
            set_mode(offm[i]); wr_tmr(16'h4242); wr_ccr(16'h0011); clr_flag();
            pulse();
            chk(ccr_value == 16'h0011 && flag == 0, "R11 pin ignored", ccr_value, 16'h0011);
        end
        set_mode(3'd2); pre_sel = 2'd0;
        wr_ccr(16'd5); wr_tmr(16'd0); clr_flag();
        tmr_run = 1'b1; step(8); tmr_run = 1'b0;
        chk(tmr_value == 8 && flag == 0, "R11 no reset in capture mode", tmr_value, 8);
    endtask

    task automatic t_irq();
        set_mode(3'd2); tmr_run = 1'b0; clr_flag(); irq_en = 1'b1; step(1);
        chk(irq == 0, "R10 no irq without flag", irq, 0);
        pulse();
        irq_en = 1'b0; step(1);
        chk(flag == 1 && irq == 0, "R10 masked", irq, 0);
        irq_en = 1'b1; step(1);
        chk(irq == 1, "R10 enabled", irq, 1);
        clr_flag();
        chk(irq == 0, "R10 cleared", irq, 0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_writes();
        t_prescale(0, 10);
        t_prescale(1, 11);
        t_prescale(2, 13);
        t_prescale(3, 30);
        t_cap_fall();
        t_cap_rise();
        t_cap_div(3'd3, 4, 16'h0444);
        t_cap_div(3'd3, 4, 16'h0555);
        t_cap_div(3'd4, 16, 16'h1616);
        t_mode_restart();
        t_compare_fast();
        t_compare_div8();
        t_set_beats_clear();
        t_ignore();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule